// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block holds the two sequencing registers of a 16-bit processor: the program counter and the stack pointer. A host issues one command at a time through a start strobe, a 3-bit operation code and a 16-bit argument. The commands are:

- advance the program counter to the next instruction word;
- jump to a target address;
- push a word;
- pop a word;
- call a subroutine;
- return from a subroutine.

The stack lives in an external word-wide synchronous RAM. That RAM is byte addressed and has a one-cycle read latency. The block drives its address, write enable, read enable and write data.

The stack grows downward in steps of 2 bytes, and the pointer always addresses the last word stored. A push lowers the pointer first and then writes. A pop reads and then raises the pointer. A call saves the current program counter on the stack and loads the target. A return reloads the program counter from the stack.

Each command takes a fixed number of cycles, which depends on the command. The end of every command is marked by a one-cycle done pulse. Popped data stays on its own output until the next pop.

Top module: `pc_stack_seq`

## Requirements
- R1: During and right after reset, pcOut equals RESET_VEC with bit 0 cleared, spOut equals STACK_TOP with bit 0 cleared, and busy and done are both 0.
- R2: Op code 0 (advance) adds 2 to the program counter modulo 2^16, so 0xFFFE becomes 0x0000. Done is high in the first cycle after the accepting clock edge.
- R3: Op code 1 (jump) loads cmdArg with bit 0 forced to 0 into the program counter. Done is high in the second cycle after the accepting edge.
- R4: Op code 2 (push) lowers the stack pointer by 2 and then writes cmdArg to the RAM at the new pointer address. Done is high in the second cycle after the accepting edge.
- R5: Op code 3 (pop) reads the word at the current pointer address onto popData and then raises the pointer by 2. Done is high in the third cycle after the accepting edge.
- R6: Op code 4 (call) lowers the stack pointer by 2, writes the program counter value from before the call at the new address, and loads cmdArg with bit 0 cleared into the program counter. Done timing is the same as for push.
- R7: Op code 5 (return) loads the program counter from the word at the pointer address, with bit 0 cleared, and then raises the pointer by 2. Done timing is the same as for pop.
- R8: Op codes 6 and 7 change neither register and touch no memory. Done is high in the first cycle after the accepting edge.
- R9: A start strobe that arrives while busy is 1 is ignored.
- R10: Done is never high for two cycles in a row. The RAM write enable and read enable are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Command strobe, accepted only when idle |
| cmdOp | input | 3 | Operation code |
| cmdArg | input | 16 | Push data or jump/call target |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| popData | output | 16 | Word returned by the last pop |
| pcOut | output | 16 | Program counter |
| spOut | output | 16 | Stack pointer |
| memWe | output | 1 | RAM write enable |
| memRe | output | 1 | RAM read enable |
| memAddr | output | 16 | RAM byte address |
| memWdata | output | 16 | RAM write data |
| memRdata | input | 16 | RAM read data, valid the cycle after memRe |

## Verification
The program counter is tried with jumps to a sweep of 64 targets, including odd ones, and each jump is followed by an advance. This separates bit-0 masking from the increment, and a jump to 0xFFFE shows whether the advance wraps.

A run of 40 distinct pushes followed by 40 pops checks the write addresses and the last-in-first-out order, and checks that the pointer comes back to its start value.

Nested calls and returns 8 deep show whether the return address that was saved is the program counter from before each call.

The reserved codes, and a start strobe given in the middle of a push, show that neither changes any register.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_ADV  = 3'd0,
    OP_JMP  = 3'd1,
    OP_PUSH = 3'd2,
    OP_POP  = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } opCode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_SETTLE = 2'd2,
    ST_FINISH = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchArg;
    logic pcAdvance;
    logic pcLoadArg;
    logic pcLoadMem;
    logic spDec;
    logic spInc;
    logic capture;
    logic memWe;
    logic memRe;
    logic wdataFromPc;
  } dpCtrl_t;

endpackage

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdStart,
  input  opCode_e cmdOp,
  output dpCtrl_t ctrl,
  output logic    busy,
  output logic    done
);

  seqState_e state, stateNext;
  opCode_e   opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= OP_ADV;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && cmdStart) opReg <= cmdOp;
    end
  end

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          ctrl.latchArg = 1'b1;
          unique case (cmdOp)
            OP_ADV: begin
              ctrl.pcAdvance = 1'b1;
              stateNext      = ST_FINISH;
            end
            OP_JMP: stateNext = ST_ACCESS;
            OP_PUSH, OP_CALL: begin
              ctrl.spDec = 1'b1;
              stateNext  = ST_ACCESS;
            end
            OP_POP, OP_RET: stateNext = ST_ACCESS;
            default: stateNext = ST_FINISH;
          endcase
        end
      end
      ST_ACCESS: begin
        unique case (opReg)
          OP_JMP: begin
            ctrl.pcLoadArg = 1'b1;
            stateNext      = ST_FINISH;
          end
          OP_PUSH: begin
            ctrl.memWe = 1'b1;
            stateNext  = ST_FINISH;
          end
          OP_CALL: begin
            ctrl.memWe       = 1'b1;
            ctrl.wdataFromPc = 1'b1;
            ctrl.pcLoadArg   = 1'b1;
            stateNext        = ST_FINISH;
          end
          OP_POP, OP_RET: begin
            ctrl.memRe = 1'b1;
            stateNext  = ST_SETTLE;
          end
          default: stateNext = ST_FINISH;
        endcase
      end
      ST_SETTLE: begin
        ctrl.spInc = 1'b1;
        if (opReg == OP_RET) ctrl.pcLoadMem = 1'b1;
        else                 ctrl.capture   = 1'b1;
        stateNext = ST_FINISH;
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_mem_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.memWe && ctrl.memRe));

  // R9: the latched op code only moves when the sequencer is idle
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stateNext != ST_IDLE) |=> $stable(opReg));

  // R5: a read is always followed by the settle step
  assert_read_then_settle_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.memRe |=> (state == ST_SETTLE));

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] RESET_VEC = 16'hC000,
  parameter logic [15:0] STACK_TOP = 16'h0400
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] cmdArg,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [ADDR_W-1:0] popData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata
);

  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] EVEN     = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] PC_INIT  = ADDR_W'(RESET_VEC) & EVEN;
  localparam logic [ADDR_W-1:0] SP_INIT  = ADDR_W'(STACK_TOP) & EVEN;

  logic [ADDR_W-1:0] pc, sp, argReg, popReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= PC_INIT;
      sp     <= SP_INIT;
      argReg <= '0;
      popReg <= '0;
    end else begin
      if (ctrl.latchArg) argReg <= cmdArg;
      if (ctrl.pcAdvance)      pc <= (pc + STEP) & EVEN;
      else if (ctrl.pcLoadArg) pc <= argReg & EVEN;
      else if (ctrl.pcLoadMem) pc <= memRdata & EVEN;
      if (ctrl.spDec)      sp <= (sp - STEP) & EVEN;
      else if (ctrl.spInc) sp <= (sp + STEP) & EVEN;
      if (ctrl.capture) popReg <= memRdata;
    end
  end

  assign pcOut    = pc;
  assign spOut    = sp;
  assign popData  = popReg;
  assign memAddr  = sp;
  assign memWdata = ctrl.wdataFromPc ? pc : argReg;

  assert_adv_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcAdvance |=> pc == ADDR_W'($past(pc) + STEP));

  assert_jump_even_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcLoadArg |=> (pc[0] == 1'b0 && pc[ADDR_W-1:1] == $past(argReg[ADDR_W-1:1])));

  assert_push_pre_dec_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.spDec |=> sp == ADDR_W'($past(sp) - STEP));

  assert_pop_post_inc_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.spInc |=> sp == ADDR_W'($past(sp) + STEP));

  assert_ret_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pcLoadMem |=> pc[ADDR_W-1:1] == $past(memRdata[ADDR_W-1:1]));

endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
  import pcs_pkg::*;
#(
  parameter logic [15:0] RESET_VEC = 16'hC000,
  parameter logic [15:0] STACK_TOP = 16'h0400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic [2:0]  cmdOp,
  input  logic [15:0] cmdArg,
  output logic        busy,
  output logic        done,
  output logic [15:0] popData,
  output logic [15:0] pcOut,
  output logic [15:0] spOut,
  output logic        memWe,
  output logic        memRe,
  output logic [15:0] memAddr,
  output logic [15:0] memWdata,
  input  logic [15:0] memRdata
);

  dpCtrl_t ctrl;

  pcs_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdOp    (opCode_e'(cmdOp)),
    .ctrl     (ctrl),
    .busy     (busy),
    .done     (done)
  );

  pcs_datapath #(
    .ADDR_W    (16),
    .RESET_VEC (RESET_VEC),
    .STACK_TOP (STACK_TOP)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cmdArg   (cmdArg),
    .memRdata (memRdata),
    .pcOut    (pcOut),
    .spOut    (spOut),
    .popData  (popData),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

  assign memWe = ctrl.memWe;
  assign memRe = ctrl.memRe;

endmodule

// File: tb/tb_pc_stack_seq.sv
module tb_pc_stack_seq;

  localparam logic [15:0] RV = 16'hC000;
  localparam logic [15:0] ST = 16'h0400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [15:0] cmdArg = 16'd0;
  logic busy, done, memWe, memRe;
  logic [15:0] popData, pcOut, spOut, memAddr, memWdata;
  logic [15:0] memRdata = 16'd0;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  logic [15:0] wrAddr = 16'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] ram [0:1023];
  logic [15:0] expPc, expSp;
  logic [15:0] shadow [0:63];

  always #2.5 clk = ~clk;

  pc_stack_seq #(.RESET_VEC(RV), .STACK_TOP(ST)) dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .busy(busy), .done(done), .popData(popData), .pcOut(pcOut), .spOut(spOut),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // synchronous RAM, one-cycle read latency
  always @(posedge clk) begin
    if (memWe) begin
      ram[memAddr[10:1]] <= memWdata;
      wrAddr  <= memAddr;
      wrData  <= memWdata;
      wrCount <= wrCount + 1;
    end
    if (memRe) memRdata <= ram[memAddr[10:1]];
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one command and return cycles until done
  task automatic runCmd(input logic [2:0] op, input logic [15:0] arg, output int lat);
    @(negedge clk);
    cmdOp = op; cmdArg = arg; cmdStart = 1'b1;
    lat = 0;
    forever begin
      @(negedge clk);
      cmdStart = 1'b0;
      lat++;
      if (done || lat > 20) break;
    end
    @(negedge clk);
    chk("R10 done single pulse", {15'd0, done}, 16'd0);
  endtask

  int wdCycles = 0;
  always @(posedge clk) begin
    wdCycles <= wdCycles + 1;
    if (memWe && memRe) begin
      failures++;
      $display("FAIL R10 memWe and memRe both high actual=1 expected=0");
    end
  end

  initial begin
    wait (wdCycles > 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<150000", wdCycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    int wc;
    logic [15:0] t;
    for (int i = 0; i < 1024; i++) ram[i] = 16'd0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pcOut, RV);
    chk("R1 sp in reset", spOut, ST);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 pc after reset", pcOut, RV);
    chk("R1 sp after reset", spOut, ST);
    chk("R1 busy/done idle", {14'd0, busy, done}, 16'd0);
    expPc = RV; expSp = ST;

    // jump sweep with advance after each (R2, R3)
    for (int k = 0; k < 64; k++) begin
      t = (k == 63) ? 16'hFFFF : 16'((k * 1031) ^ (k << 9));
      runCmd(3'd1, t, lat);
      chk("R3 jump latency", 16'(lat), 16'd2);
      expPc = t & 16'hFFFE;
      chk("R3 jump target even", pcOut, expPc);
      runCmd(3'd0, 16'h1234, lat);
      chk("R2 advance latency", 16'(lat), 16'd1);
      expPc = expPc + 16'd2;
      chk("R2 advance by two", pcOut, expPc);
    end
    chk("R2 wrap to zero", pcOut, 16'h0000);

    // push sweep (R4)
    for (int k = 0; k < 40; k++) begin
      shadow[k] = 16'(16'hA5A5 ^ (k * 16'h0907));
      runCmd(3'd2, shadow[k], lat);
      expSp = expSp - 16'd2;
      chk("R4 push latency", 16'(lat), 16'd2);
      chk("R4 sp pre-decrement", spOut, expSp);
      chk("R4 write address", wrAddr, expSp);
      chk("R4 write data", wrData, shadow[k]);
    end
    // pop sweep, LIFO (R5)
    for (int k = 39; k >= 0; k--) begin
      runCmd(3'd3, 16'h0, lat);
      expSp = expSp + 16'd2;
      chk("R5 pop latency", 16'(lat), 16'd3);
      chk("R5 pop data", popData, shadow[k]);
      chk("R5 sp post-increment", spOut, expSp);
    end
    chk("R5 sp back at top", spOut, ST);

    // nested call/return (R6, R7)
    runCmd(3'd1, 16'h8000, lat);
    expPc = 16'h8000;
    for (int k = 0; k < 8; k++) begin
      shadow[k] = expPc;
      t = 16'(16'h9001 + k * 16'h0102);
      runCmd(3'd4, t, lat);
      expSp = expSp - 16'd2;
      expPc = t & 16'hFFFE;
      chk("R6 call latency", 16'(lat), 16'd2);
      chk("R6 call target", pcOut, expPc);
      chk("R6 call sp", spOut, expSp);
      chk("R6 saved pc", wrData, shadow[k]);
      chk("R6 saved address", wrAddr, expSp);
      runCmd(3'd0, 16'h0, lat);
      expPc = expPc + 16'd2;
    end
    for (int k = 7; k >= 0; k--) begin
      runCmd(3'd5, 16'h0, lat);
      expSp = expSp + 16'd2;
      chk("R7 ret latency", 16'(lat), 16'd3);
      chk("R7 ret pc", pcOut, shadow[k]);
      chk("R7 ret sp", spOut, expSp);
    end
    expPc = shadow[0];

    // return of an odd stored word clears bit 0 (R7)
    runCmd(3'd2, 16'h4321, lat);
    runCmd(3'd5, 16'h0, lat);
    chk("R7 ret odd word masked", pcOut, 16'h4320);
    chk("R7 ret odd sp", spOut, ST);
    expPc = 16'h4320;

    // reserved codes (R8)
    for (int c = 6; c <= 7; c++) begin
      wc = wrCount;
      runCmd(3'(c), 16'hFFFF, lat);
      chk("R8 reserved latency", 16'(lat), 16'd1);
      chk("R8 reserved pc", pcOut, expPc);
      chk("R8 reserved sp", spOut, expSp);
      chk("R8 reserved no write", 16'(wrCount - wc), 16'd0);
    end

    // start while busy ignored (R9)
    @(negedge clk);
    cmdOp = 3'd2; cmdArg = 16'h5A5A; cmdStart = 1'b1;
    @(negedge clk);
    chk("R9 busy during push", {15'd0, busy}, 16'd1);
    cmdOp = 3'd1; cmdArg = 16'h2222; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    chk("R9 done after push", {15'd0, done}, 16'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R9 pc unchanged", pcOut, expPc);
    chk("R9 sp single push", spOut, ST - 16'd2);
    chk("R9 busy cleared", {15'd0, busy}, 16'd0);
    chk("R9 pushed word", wrData, 16'h5A5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule